// File: doc/BRIEF.md
# Lockable Vendor Capability Register Block

This block holds one vendor-defined extended capability inside a byte-addressed configuration space. It has a word-aligned write port with per-lane byte enables and a registered 32-bit read port. A read-only identification word packs a 12-bit length, a 4-bit revision and a 16-bit vendor code, all taken from parameters. The writable part is a 16-bit control field and a small set of sticky status bits. A write-once lock bit freezes control and any number of memory range base pairs. Each pair has a fully writable upper word and a lower word whose only writable bits hold the 256 MiB-aligned part of the base.

Every writable bit is masked per byte. Bits outside the masks read as zero. Status bits are set by hardware event inputs and cleared by software writing 1. The control bits have no side effects here; other logic reads them through the configuration path.

Top module: `cfg_cap_lock`

## Requirements
- R1: The word at byte offset 0x00 reads {length[11:0] in bits 31:20, revision[3:0] in bits 19:16, vendor[15:0] in bits 15:0}, and writes to it have no effect.
- R2: The control field is bits 15:0 of the word at 0x04. Only the bits of write mask 0x4FFD (0xFD in the low byte, 0x4F in the high byte) take written data. All other control bits read 0.
- R3: Status occupies bits 19:16 of the word at 0x04. A 1 on evt_set[i] sets bit i one cycle later. Writing 1 to the bit with byte lane 2 enabled clears it, and writing 0 leaves it unchanged. If a set and a clear land in the same cycle, the set wins. Bits 31:20 read 0. The lock does not affect status.
- R4: The lock is bit 0 of the word at 0x08, and its other bits read 0. A write with lane 0 enabled and data bit 0 high sets it. Once it is set, no write clears it; only a reset does.
- R5: Starting the cycle after the lock is set, writes to the control field and to every range base word are ignored.
- R6: Range i has an upper base word at 0x0C+8*i, with all 32 bits writable.
- R7: Range i has a lower base word at 0x10+8*i. Only bits 31:28 are writable, and bits 27:0 read 0.
- R8: Each byte enable wr_be[k] gates data bits 8k+7:8k independently on every writable word.
- R9: An active-low por_n resets everything asynchronously, including status. A synchronous soft_rst clears control, lock and range bases, but status is kept.
- R10: Reads of unmapped or misaligned byte addresses return 0, and writes to them change no state.
- R11: A read request with rd_en high returns rd_valid high and the data on the following cycle. The data reflects the state before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous soft reset; status survives it |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_be | input | 4 | Byte lane enables for the write |
| wr_data | input | 32 | Write data |
| evt_set | input | STS_W | Hardware events that set status bits |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data |

## Verification
A bad lock state shows up at the ports as a control or range word that moves after locking, or that stays stuck after unlocking. The bench finds it by reading back the word on the cycle after the blocked write. A status corruption, such as a lost event, a missed clear, or an unwanted clear on soft reset, appears in the 0x04 word on the next read. Mask errors reveal themselves as soon as an all-ones write is read back, because every non-mask bit must read zero.

// File: rtl/cfg_cap_lock.sv
module cfg_cap_lock #(
  parameter logic [11:0] CAP_LEN   = 12'h038,
  parameter logic [3:0]  CAP_REV   = 4'h1,
  parameter logic [15:0] VENDOR_ID = 16'h5A3C,
  parameter int          ADDR_W    = 8,
  parameter int          N_RANGE   = 2,
  parameter int          STS_W     = 4,
  parameter logic [15:0] CTRL_MASK = 16'h4FFD
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [3:0]        wr_be,
  input  logic [31:0]       wr_data,
  input  logic [STS_W-1:0]  evt_set,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [31:0]       rd_data
);

  localparam int WORD_W   = ADDR_W - 2;
  localparam int W_ID     = 0;
  localparam int W_CTRL   = 1;
  localparam int W_LOCK   = 2;
  localparam int W_RANGE  = 3;
  localparam int STS_LSB  = 16;
  localparam logic [31:0] IDENT = {CAP_LEN, CAP_REV, VENDOR_ID};

  logic [WORD_W-1:0] wr_word, rd_word;
  logic              wr_ok, rd_ok;
  logic [31:0]       be_bits;
  logic [15:0]       ctrl_m;
  logic              hit_ctrl, hit_lock;
  logic [STS_W-1:0]  sts_clr;

  logic [15:0]       ctrl_q;
  logic [STS_W-1:0]  sts_q;
  logic              lock_q;
  logic [31:0]       rhi_q [N_RANGE];
  logic [3:0]        rlo_q [N_RANGE];
  logic [31:0]       rd_mux;

  assign wr_word  = wr_addr[ADDR_W-1:2];
  assign rd_word  = rd_addr[ADDR_W-1:2];
  assign wr_ok    = wr_en && (wr_addr[1:0] == 2'b00);
  assign rd_ok    = (rd_addr[1:0] == 2'b00);
  assign be_bits  = {{8{wr_be[3]}}, {8{wr_be[2]}}, {8{wr_be[1]}}, {8{wr_be[0]}}};
  assign ctrl_m   = CTRL_MASK & be_bits[15:0];
  assign hit_ctrl = wr_ok && (wr_word == WORD_W'(W_CTRL));
  assign hit_lock = wr_ok && (wr_word == WORD_W'(W_LOCK));
  assign sts_clr  = hit_ctrl ? (wr_data[STS_LSB +: STS_W] & {STS_W{wr_be[2]}}) : '0;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ctrl_q <= '0;
      lock_q <= 1'b0;
      for (int i = 0; i < N_RANGE; i++) begin
        rhi_q[i] <= '0;
        rlo_q[i] <= '0;
      end
    end else if (soft_rst) begin
      ctrl_q <= '0;
      lock_q <= 1'b0;
      for (int i = 0; i < N_RANGE; i++) begin
        rhi_q[i] <= '0;
        rlo_q[i] <= '0;
      end
    end else begin
      if (hit_ctrl && !lock_q)
        ctrl_q <= (ctrl_q & ~ctrl_m) | (wr_data[15:0] & ctrl_m);
      if (hit_lock && wr_be[0] && wr_data[0])
        lock_q <= 1'b1;
      for (int i = 0; i < N_RANGE; i++) begin
        if (wr_ok && !lock_q && wr_word == WORD_W'(W_RANGE + 2*i))
          rhi_q[i] <= (rhi_q[i] & ~be_bits) | (wr_data & be_bits);
        if (wr_ok && !lock_q && wr_word == WORD_W'(W_RANGE + 2*i + 1) && wr_be[3])
          rlo_q[i] <= wr_data[31:28];
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~sts_clr) | evt_set;
  end

  always_comb begin
    rd_mux = '0;
    if (rd_ok) begin
      if (rd_word == WORD_W'(W_ID))   rd_mux = IDENT;
      if (rd_word == WORD_W'(W_CTRL)) rd_mux = 32'(ctrl_q) | (32'(sts_q) << STS_LSB);
      if (rd_word == WORD_W'(W_LOCK)) rd_mux = 32'(lock_q);
      for (int i = 0; i < N_RANGE; i++) begin
        if (rd_word == WORD_W'(W_RANGE + 2*i))     rd_mux = rhi_q[i];
        if (rd_word == WORD_W'(W_RANGE + 2*i + 1)) rd_mux = {rlo_q[i], 28'h0};
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  // R4: lock never drops without a reset
  p_lock_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
    lock_q && !soft_rst |=> lock_q);

  // R5: control frozen while locked
  p_ctrl_frozen_r5: assert property (@(posedge clk) disable iff (!por_n)
    lock_q && !soft_rst |=> $stable(ctrl_q));

  // R3: an event always lands in status
  p_evt_sets_r3: assert property (@(posedge clk) disable iff (!por_n)
    (|evt_set) |=> ((sts_q & $past(evt_set)) == $past(evt_set)));

  // R3, R9: a set status bit survives unless cleared by a write of 1
  p_sts_keep_r3: assert property (@(posedge clk) disable iff (!por_n)
    (|sts_q) |=> ((sts_q & $past(sts_q & ~sts_clr)) == $past(sts_q & ~sts_clr)));

  // R9: soft reset clears control and lock
  p_soft_clear_r9: assert property (@(posedge clk) disable iff (!por_n)
    soft_rst |=> (!lock_q && ctrl_q == '0));

  // R11: one-cycle read latency
  p_rd_latency_r11: assert property (@(posedge clk) disable iff (!por_n)
    rd_en |=> rd_valid);
  p_rd_idle_r11: assert property (@(posedge clk) disable iff (!por_n)
    !rd_en |=> !rd_valid);

  for (genvar g = 0; g < N_RANGE; g++) begin : g_rng_chk
    // R5: range bases frozen while locked
    p_range_frozen_r5: assert property (@(posedge clk) disable iff (!por_n)
      lock_q && !soft_rst |=> ($stable(rhi_q[g]) && $stable(rlo_q[g])));
  end

endmodule

// File: tb/cfg_cap_lock_tb_top.sv
module cfg_cap_lock_tb_top;
  localparam int AW = 8;
  localparam logic [31:0] IDENT = 32'h03C2_5A3C;

  logic clk = 0;
  logic por_n = 0, soft_rst = 0, wr_en = 0, rd_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [3:0] wr_be = '0, evt_set = '0;
  logic [31:0] wr_data = '0;
  logic rd_valid;
  logic [31:0] rd_data;

  always #2 clk = ~clk;

  cfg_cap_lock #(.CAP_LEN(12'h03C), .CAP_REV(4'h2), .VENDOR_ID(16'h5A3C),
                 .ADDR_W(AW), .N_RANGE(2), .STS_W(4), .CTRL_MASK(16'h4FFD)) dut_i (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_be(wr_be), .wr_data(wr_data), .evt_set(evt_set), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data));

  int vectors = 0, miscmp = 0, cyc = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  logic [15:0] m_ctrl;
  logic [3:0]  m_sts;
  logic        m_lock;
  logic [31:0] m_hi [2];
  logic [3:0]  m_lo [2];

  task automatic m_clear(input bit keep_sts);
    m_ctrl = 0; m_lock = 0;
    if (!keep_sts) m_sts = 0;
    for (int i = 0; i < 2; i++) begin m_hi[i] = 0; m_lo[i] = 0; end
  endtask

  function automatic logic [31:0] m_word(input logic [AW-1:0] a);
    if (a[1:0] != 0) return 0;
    case (a)
      8'h00: return IDENT;
      8'h04: return {12'h0, m_sts, m_ctrl};
      8'h08: return {31'h0, m_lock};
      8'h0C: return m_hi[0];
      8'h10: return {m_lo[0], 28'h0};
      8'h14: return m_hi[1];
      8'h18: return {m_lo[1], 28'h0};
      default: return 0;
    endcase
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [3:0] be, input logic [31:0] d,
                    input logic [3:0] ev = 4'h0);
    logic [31:0] bm;
    logic [15:0] cm;
    logic [3:0] clr;
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_be = be; wr_data = d; evt_set = ev;
    @(negedge clk);
    wr_en = 0; evt_set = 0;
    bm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    cm = 16'h4FFD & bm[15:0];
    clr = (a == 8'h04) ? (d[19:16] & {4{be[2]}}) : 4'h0;
    if (!m_lock) begin
      if (a == 8'h04) m_ctrl = (m_ctrl & ~cm) | (d[15:0] & cm);
      for (int i = 0; i < 2; i++) begin
        if (a == AW'(8'h0C + 8*i)) m_hi[i] = (m_hi[i] & ~bm) | (d & bm);
        if (a == AW'(8'h10 + 8*i) && be[3]) m_lo[i] = d[31:28];
      end
    end
    if (a == 8'h08 && be[0] && d[0]) m_lock = 1;
    m_sts = (m_sts & ~clr) | ev;
  endtask

  task automatic evt(input logic [3:0] ev);
    @(negedge clk); evt_set = ev;
    @(negedge clk); evt_set = 0;
    m_sts = m_sts | ev;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    exp_q.push_back(m_word(a));
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic rd_all(input string tag);
    for (int i = 0; i < 7; i++) rd(AW'(4*i), tag);
  endtask

  always @(negedge clk) begin
    if (rd_valid) begin
      vectors++;
      if (exp_q.size() == 0) begin
        miscmp++;
        $display("FAIL R11 unexpected rd_valid actual=%h expected=none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          miscmp++;
          $display("FAIL %s actual=%h expected=%h", t, rd_data, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      miscmp++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  initial begin
    m_clear(0);
    repeat (3) @(negedge clk);
    por_n = 1;
    rd_all("R9 reset state");
    rd(8'h3C, "R10 unmapped read");
    rd(8'h05, "R10 misaligned read");
    wr(8'h00, 4'hF, 32'hFFFF_FFFF);
    rd(8'h00, "R1 ident read-only");
    wr(8'h04, 4'h3, 32'h0000_FFFF);
    rd(8'h04, "R2 control mask");
    wr(8'h04, 4'h1, 32'h0000_0000);
    rd(8'h04, "R8 low lane only");
    wr(8'h04, 4'h2, 32'h0000_1234);
    rd(8'h04, "R8 high lane only");
    wr(8'h04, 4'hC, 32'hFFF0_0000);
    rd(8'h04, "R3 reserved status bits");
    evt(4'b0101);
    rd(8'h04, "R3 event sets");
    wr(8'h04, 4'h4, 32'h0000_0000);
    rd(8'h04, "R3 write zero keeps");
    wr(8'h04, 4'h4, 32'h0001_0000);
    rd(8'h04, "R3 write one clears");
    wr(8'h04, 4'h4, 32'h0004_0000, 4'b0100);
    rd(8'h04, "R3 set wins over clear");
    evt(4'b1000);
    rd(8'h04, "R3 second event");
    wr(8'h0C, 4'hF, 32'hDEAD_BEEF);
    wr(8'h14, 4'h5, 32'h1234_5678);
    rd(8'h0C, "R6 range0 high");
    rd(8'h14, "R8 range1 high lanes");
    wr(8'h10, 4'hF, 32'hFFFF_FFFF);
    rd(8'h10, "R7 range0 low mask");
    wr(8'h18, 4'h7, 32'hA5A5_A5A5);
    rd(8'h18, "R7 low without lane 3");
    wr(8'h18, 4'h8, 32'hA5A5_A5A5);
    rd(8'h18, "R7 low lane 3");
    wr(8'h08, 4'hF, 32'h0000_0000);
    rd(8'h08, "R4 lock zero write");
    wr(8'h08, 4'hE, 32'hFFFF_FFFF);
    rd(8'h08, "R4 lock needs lane 0");
    wr(8'h3C, 4'hF, 32'hFFFF_FFFF);
    wr(8'h05, 4'hF, 32'hFFFF_FFFF);
    rd_all("R10 ignored writes");
    wr(8'h08, 4'h1, 32'hFFFF_FFFF);
    wr(8'h04, 4'h3, 32'h0000_0000);
    wr(8'h0C, 4'hF, 32'h0000_0000);
    wr(8'h18, 4'h8, 32'h5000_0000);
    wr(8'h08, 4'hF, 32'h0000_0000);
    rd_all("R5 locked writes ignored");
    wr(8'h04, 4'h4, 32'h0008_0000);
    rd(8'h04, "R3 clear while locked");
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
    m_clear(1);
    rd_all("R9 soft reset keeps status");
    wr(8'h04, 4'h1, 32'h0000_0001);
    rd(8'h04, "R4 unlocked after reset");
    @(negedge clk); por_n = 0;
    @(negedge clk); por_n = 1;
    m_clear(0);
    rd_all("R9 por clears all");
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      vectors++; miscmp++;
      $display("FAIL R11 reads without rd_valid actual=%0d expected=0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule